// File: doc/BRIEF.md
# Floating-Point Ordered Compare Unit

This unit decides whether one floating-point operand is less than, or less than or equal to, another, and returns the answer as an integer 0 or 1 together with an invalid-operation flag. Each comparison comes in two flavours. The signalling flavour raises the flag for any NaN operand. The quiet flavour raises it only for a signalling NaN. In the instruction encoding, the quiet flavour is the signalling one with instruction bit 14 set. A decoder passes that bit straight to the quiet-select input of this unit.

Single precision is always present. Double, half and quad precision are each switched on by a parameter. A narrower format reads only the low bits of the operand buses. A request is accepted on any clock edge where the valid input is high. The result appears one cycle later and is held until the next accepted request.

Top module: `fcmp_unit`

## Requirements
- R1: With the less-than operation selected (`inLt`=1) and neither operand NaN, the result is 1 exactly when A is numerically below B, for either sign and for infinities.
- R2: With the less-or-equal operation selected (`inLt`=0) and neither operand NaN, the result is 1 exactly when A is numerically below or equal to B.
- R3: Zeros of opposite sign are equal, so less-or-equal gives 1 and less-than gives 0 for that pair, in either order.
- R4: If either operand is a NaN (exponent all ones, fraction non-zero), the result is 0, whatever the operation or flavour.
- R5: In the signalling flavour (`inQuiet`=0), any NaN operand, quiet or signalling, sets the invalid flag.
- R6: In the quiet flavour (`inQuiet`=1), quiet NaN operands (fraction MSB = 1) leave the invalid flag at 0.
- R7: In the quiet flavour, a signalling NaN operand (fraction MSB = 0) still sets the invalid flag.
- R8: The result is driven as an XLEN-bit integer whose bits above bit 0 are always 0.
- R9: `outValid` is high exactly one cycle after a cycle with `inValid` high. The result and flag change only on accepted requests and otherwise hold.
- R10: The format code selects single (0), double (1), half (2) or quad (3). A format of width W reads bits W-1:0 of each operand, and higher bits have no effect.
- R11: A request for a format disabled by parameter returns result 0 and flag 0.
- R12: During and right after reset, `outValid`, the result and the flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request accepted this edge |
| inFmt | input | 2 | Format: 0 single, 1 double, 2 half, 3 quad |
| inLt | input | 1 | 1 selects less-than, 0 selects less-or-equal |
| inQuiet | input | 1 | 1 selects the quiet flavour (encoding bit 14) |
| opA | input | FLEN | Left operand |
| opB | input | FLEN | Right operand |
| outValid | output | 1 | Result valid, one cycle after the request |
| outResult | output | XLEN | Zero-extended boolean result |
| outInvalid | output | 1 | Invalid-operation flag |

## Verification
The bench mixes quiet and signalling NaNs in every format under both flavours. A unit that ignored the quiet select, or that tested the wrong fraction bit for quietness, would raise or drop the flag on the wrong inputs.

Opposite-signed zeros and pairs of negative operands are driven as well. Those catch a comparator that orders raw bit patterns, which would report -0 below +0 and invert the order of negative values.

Half- and single-precision requests carry junk in the upper operand bits, so a decoder that reads the wrong slice would change the answer. A second instance built without quad precision must answer 0 with no flag, even for NaN quad operands.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int NUM_FMT = 4;

  // Format codes double as indices into per-format vectors.
  typedef enum logic [1:0] {
    FMT_S = 2'd0,
    FMT_D = 2'd1,
    FMT_H = 2'd2,
    FMT_Q = 2'd3
  } fmt_e;

  typedef struct packed {
    logic               load;
    logic [NUM_FMT-1:0] fmtSel;
    logic               ltOp;
    logic               quiet;
  } strobe_t;

  function automatic int fmtWidth(input int idx);
    case (idx)
      0:       return 32;
      1:       return 64;
      2:       return 16;
      default: return 128;
    endcase
  endfunction

  function automatic int fmtExpW(input int idx);
    case (idx)
      0:       return 8;
      1:       return 11;
      2:       return 5;
      default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
#(
  parameter bit EN_DOUBLE = 1'b1,
  parameter bit EN_HALF   = 1'b1,
  parameter bit EN_QUAD   = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inFmt,
  input  logic       inLt,
  input  logic       inQuiet,
  output strobe_t    strobes,
  output logic       outValid
);

  localparam logic [NUM_FMT-1:0] FMT_EN = {EN_QUAD, EN_HALF, EN_DOUBLE, 1'b1};

  logic [NUM_FMT-1:0] fmtDecode;
  logic               validQ;

  always_comb begin
    fmtDecode = '0;
    fmtDecode[inFmt] = 1'b1;
  end

  always_comb begin
    strobes.load   = inValid;
    strobes.fmtSel = fmtDecode & FMT_EN;
    strobes.ltOp   = inLt;
    strobes.quiet  = inQuiet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  assign outValid = validQ;

endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int FLEN = 128
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobes,
  input  logic [FLEN-1:0] opA,
  input  logic [FLEN-1:0] opB,
  output logic [XLEN-1:0] outResult,
  output logic            outInvalid
);

  logic [NUM_FMT-1:0] ltVec, eqVec, nanVec, snanVec;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int W = fmtWidth(g);
    localparam int E = fmtExpW(g);
    localparam int M = W - 1 - E;
    if (W <= FLEN) begin : g_on
      logic [W-1:0] a, b;
      logic [W-2:0] magA, magB;
      logic aNan, bNan, bothZero;
      assign a        = opA[W-1:0];
      assign b        = opB[W-1:0];
      assign magA     = a[W-2:0];
      assign magB     = b[W-2:0];
      assign aNan     = (&a[W-2:M]) & (|a[M-1:0]);
      assign bNan     = (&b[W-2:M]) & (|b[M-1:0]);
      assign bothZero = ~(|magA) & ~(|magB);
      assign nanVec[g]  = aNan | bNan;
      assign snanVec[g] = (aNan & ~a[M-1]) | (bNan & ~b[M-1]);
      assign eqVec[g]   = (a == b) | bothZero;
      always_comb begin
        if (bothZero)             ltVec[g] = 1'b0;
        else if (a[W-1] != b[W-1]) ltVec[g] = a[W-1];
        else if (a[W-1])          ltVec[g] = magA > magB;
        else                      ltVec[g] = magA < magB;
      end
    end else begin : g_off
      assign nanVec[g]  = 1'b0;
      assign snanVec[g] = 1'b0;
      assign eqVec[g]   = 1'b0;
      assign ltVec[g]   = 1'b0;
    end
  end

  logic selLt, selEq, selNan, selSnan, resD, invD;
  logic resQ, invQ;

  always_comb begin
    selLt = 1'b0; selEq = 1'b0; selNan = 1'b0; selSnan = 1'b0;
    for (int i = 0; i < NUM_FMT; i++) begin
      if (strobes.fmtSel[i]) begin
        selLt   = selLt   | ltVec[i];
        selEq   = selEq   | eqVec[i];
        selNan  = selNan  | nanVec[i];
        selSnan = selSnan | snanVec[i];
      end
    end
    resD = ~selNan & (strobes.ltOp ? selLt : (selLt | selEq));
    invD = strobes.quiet ? selSnan : selNan;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ <= 1'b0;
      invQ <= 1'b0;
    end else if (strobes.load) begin
      resQ <= resD;
      invQ <= invD;
    end
  end

  assign outResult  = {{(XLEN-1){1'b0}}, resQ};
  assign outInvalid = invQ;

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int FLEN      = 128,
  parameter bit EN_DOUBLE = 1'b1,
  parameter bit EN_HALF   = 1'b1,
  parameter bit EN_QUAD   = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      inFmt,
  input  logic            inLt,
  input  logic            inQuiet,
  input  logic [FLEN-1:0] opA,
  input  logic [FLEN-1:0] opB,
  output logic            outValid,
  output logic [XLEN-1:0] outResult,
  output logic            outInvalid
);

  strobe_t strobes;

  fcmp_ctrl #(
    .EN_DOUBLE(EN_DOUBLE), .EN_HALF(EN_HALF), .EN_QUAD(EN_QUAD)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFmt(inFmt),
    .inLt(inLt), .inQuiet(inQuiet), .strobes(strobes), .outValid(outValid)
  );

  fcmp_datapath #(.XLEN(XLEN), .FLEN(FLEN)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opA(opA), .opB(opB),
    .outResult(outResult), .outInvalid(outInvalid)
  );

endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk #(
  parameter int XLEN = 64,
  parameter int FLEN = 128
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [1:0]      inFmt,
  input logic            inQuiet,
  input logic [FLEN-1:0] opA,
  input logic [FLEN-1:0] opB,
  input logic            outValid,
  input logic [XLEN-1:0] outResult,
  input logic            outInvalid
);

  logic spNanA, spNanB, spReq;
  assign spNanA = (&opA[30:23]) & (|opA[22:0]);
  assign spNanB = (&opB[30:23]) & (|opB[22:0]);
  assign spReq  = inValid & (inFmt == 2'd0);

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outResult) && $stable(outInvalid)));

  assert_zero_ext_R8: assert property (@(posedge clk) disable iff (!rstN)
    outResult[XLEN-1:1] == '0);

  assert_nan_false_R4: assert property (@(posedge clk) disable iff (!rstN)
    (spReq && (spNanA || spNanB)) |=> (outResult == '0));

  assert_signal_invalid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (spReq && !inQuiet && (spNanA || spNanB)) |=> outInvalid);

endmodule

bind fcmp_unit fcmp_unit_chk #(.XLEN(XLEN), .FLEN(FLEN)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inFmt(inFmt), .inQuiet(inQuiet),
  .opA(opA), .opB(opB), .outValid(outValid), .outResult(outResult),
  .outInvalid(outInvalid)
);

// File: tb/test_fcmp_unit.sv
module test_fcmp_unit;

  localparam int XLEN = 64;
  localparam int FLEN = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inFmt = 2'd0;
  logic inLt = 1'b0;
  logic inQuiet = 1'b0;
  logic [FLEN-1:0] opA = '0;
  logic [FLEN-1:0] opB = '0;
  logic outValid, outInvalid, nqValid, nqInvalid;
  logic [XLEN-1:0] outResult, nqResult;

  int tests = 0;
  int fails = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  fcmp_unit #(.XLEN(XLEN), .FLEN(FLEN)) i_fcmp_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFmt(inFmt), .inLt(inLt),
    .inQuiet(inQuiet), .opA(opA), .opB(opB), .outValid(outValid),
    .outResult(outResult), .outInvalid(outInvalid));

  fcmp_unit #(.XLEN(XLEN), .FLEN(FLEN), .EN_QUAD(1'b0)) i_fcmp_unit_noq (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFmt(inFmt), .inLt(inLt),
    .inQuiet(inQuiet), .opA(opA), .opB(opB), .outValid(nqValid),
    .outResult(nqResult), .outInvalid(nqInvalid));

  // Reference: order-preserving key mapping over the format's bit slice.
  function automatic logic [1:0] refCmp(input logic [1:0] f, input logic [127:0] a,
      input logic [127:0] b, input logic lt, input logic q, input logic haveQuad);
    int w, e;
    logic [127:0] mask, x, y, kx, ky, one;
    logic nx, ny, sx, sy, r, inv;
    case (f)
      2'd0: begin w = 32;  e = 8;  end
      2'd1: begin w = 64;  e = 11; end
      2'd2: begin w = 16;  e = 5;  end
      default: begin w = 128; e = 15; end
    endcase
    if (f == 2'd3 && !haveQuad) return 2'b00;
    one  = 128'd1;
    mask = (w == 128) ? '1 : ((one << w) - one);
    x = a & mask;
    y = b & mask;
    nx = (((x >> (w-1-e)) & ((one << e) - one)) == ((one << e) - one)) &&
         ((x & ((one << (w-1-e)) - one)) != 0);
    ny = (((y >> (w-1-e)) & ((one << e) - one)) == ((one << e) - one)) &&
         ((y & ((one << (w-1-e)) - one)) != 0);
    sx = nx && (((x >> (w-2-e)) & one) == 0);
    sy = ny && (((y >> (w-2-e)) & one) == 0);
    if ((x & (mask >> 1)) == 0) x = 0;
    if ((y & (mask >> 1)) == 0) y = 0;
    kx = ((x >> (w-1)) & one) != 0 ? (~x & mask) : (x | (one << (w-1)));
    ky = ((y >> (w-1)) & one) != 0 ? (~y & mask) : (y | (one << (w-1)));
    r   = !(nx || ny) && (lt ? (kx < ky) : (kx <= ky));
    inv = q ? (sx || sy) : (nx || ny);
    return {r, inv};
  endfunction

  // Cycle-by-cycle model, updated at the same edge as the design.
  logic expValid = 1'b0;
  logic [1:0] expMain = 2'b00, expNoq = 2'b00;
  string expReq = "R12";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expValid <= 1'b0;
      expMain  <= 2'b00;
      expNoq   <= 2'b00;
    end else begin
      expValid <= inValid;
      if (inValid) begin
        expMain <= refCmp(inFmt, opA, opB, inLt, inQuiet, 1'b1);
        expNoq  <= refCmp(inFmt, opA, opB, inLt, inQuiet, 1'b0);
        expReq  <= curReq;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      tests++;
      if (outValid !== expValid || nqValid !== expValid) begin
        fails++;
        $display("FAIL R9 valid: got %b/%b expected %b", outValid, nqValid, expValid);
      end
      tests++;
      if (outResult !== {63'd0, expMain[1]} || outInvalid !== expMain[0]) begin
        fails++;
        $display("FAIL %s main: got res=%h inv=%b expected res=%0d inv=%b",
                 expReq, outResult, outInvalid, expMain[1], expMain[0]);
      end
      tests++;
      if (nqResult !== {63'd0, expNoq[1]} || nqInvalid !== expNoq[0]) begin
        fails++;
        $display("FAIL %s no-quad: got res=%h inv=%b expected res=%0d inv=%b",
                 expReq, nqResult, nqInvalid, expNoq[1], expNoq[0]);
      end
    end
  end

  task automatic req(input string r, input logic [1:0] f, input logic [127:0] a,
                     input logic [127:0] b, input logic lt, input logic q);
    @(negedge clk);
    curReq = r; inFmt = f; opA = a; opB = b; inLt = lt; inQuiet = q; inValid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = {4{32'hDEADBEEF}};
      opB = '0;
    end
  endtask

  localparam logic [127:0] S1 = 128'h3F800000, S2 = 128'h40000000;
  localparam logic [127:0] SN1 = 128'hBF800000, SN2 = 128'hC0000000;
  localparam logic [127:0] SPZ = 128'h0, SNZ = 128'h80000000;
  localparam logic [127:0] SQN = 128'h7FC00000, SSN = 128'h7F800001;
  localparam logic [127:0] SINF = 128'h7F800000, SNINF = 128'hFF800000;
  localparam logic [127:0] D1 = 128'h3FF0000000000000, D2 = 128'h4000000000000000;
  localparam logic [127:0] DQN = 128'h7FF8000000000000, DSN = 128'h7FF0000000000001;
  localparam logic [127:0] H1 = 128'h3C00, H2 = 128'h4000, HQN = 128'h7E00, HSN = 128'h7C01;
  localparam logic [127:0] Q1 = {16'h3FFF, 112'd0}, Q2 = {16'h4000, 112'd0};
  localparam logic [127:0] QQN = {16'h7FFF, 16'h8000, 96'd0}, QSN = {16'h7FFF, 111'd0, 1'b1};
  localparam logic [127:0] JUNK = {96'hA5A5_5A5A_FFFF_0000_1234_5678, 32'd0};

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (outValid !== 1'b0 || outResult !== '0 || outInvalid !== 1'b0) begin
      fails++;
      $display("FAIL R12: got v=%b r=%h i=%b expected 0/0/0", outValid, outResult, outInvalid);
    end
    rstN = 1'b1;
    @(negedge clk);
    tests++;
    if (outValid !== 1'b0 || outResult !== '0 || outInvalid !== 1'b0) begin
      fails++;
      $display("FAIL R12 after release: got v=%b r=%h i=%b expected 0/0/0",
               outValid, outResult, outInvalid);
    end

    // R1 less-than, ordered operands
    req("R1", 2'd0, S1, S2, 1'b1, 1'b0);
    req("R1", 2'd0, S2, S1, 1'b1, 1'b0);
    req("R1", 2'd0, SN2, SN1, 1'b1, 1'b0);
    req("R1", 2'd0, SN1, SN2, 1'b1, 1'b1);
    req("R1", 2'd0, SNINF, SINF, 1'b1, 1'b0);
    req("R1", 2'd0, S1, S1, 1'b1, 1'b0);
    // R2 less-or-equal
    req("R2", 2'd0, S1, S1, 1'b0, 1'b0);
    req("R2", 2'd0, S2, S1, 1'b0, 1'b1);
    req("R2", 2'd0, SN1, S1, 1'b0, 1'b0);
    req("R2", 2'd0, SN1, SN2, 1'b0, 1'b0);
    // R3 signed zeros
    req("R3", 2'd0, SNZ, SPZ, 1'b0, 1'b0);
    req("R3", 2'd0, SPZ, SNZ, 1'b0, 1'b0);
    req("R3", 2'd0, SNZ, SPZ, 1'b1, 1'b0);
    req("R3", 2'd0, SPZ, SNZ, 1'b1, 1'b1);
    // R4 / R5 signalling flavour with NaNs
    req("R5", 2'd0, SQN, S1, 1'b1, 1'b0);
    req("R5", 2'd0, S1, SSN, 1'b0, 1'b0);
    req("R4", 2'd0, SQN, SQN, 1'b0, 1'b0);
    // R6 / R7 quiet flavour
    req("R6", 2'd0, SQN, S1, 1'b1, 1'b1);
    req("R6", 2'd0, S1, SQN, 1'b0, 1'b1);
    req("R7", 2'd0, SSN, S1, 1'b1, 1'b1);
    req("R7", 2'd0, SQN, SSN, 1'b0, 1'b1);
    idle(2);
    // R9 hold after idle, then R8 with a true result (upper bits still zero)
    req("R8", 2'd0, SN1, S1, 1'b1, 1'b0);
    idle(3);
    // R10 formats, with junk above the active slice
    req("R10", 2'd1, D1, D2, 1'b1, 1'b0);
    req("R10", 2'd1, D2, D1, 1'b0, 1'b0);
    req("R6", 2'd1, DQN, D1, 1'b1, 1'b1);
    req("R7", 2'd1, D1, DSN, 1'b1, 1'b1);
    req("R10", 2'd2, H1 | JUNK, H2, 1'b1, 1'b0);
    req("R10", 2'd2, H2, H1 | (JUNK >> 8), 1'b0, 1'b0);
    req("R6", 2'd2, HQN, H1, 1'b0, 1'b1);
    req("R7", 2'd2, HSN, H1, 1'b0, 1'b1);
    req("R10", 2'd0, S1 | JUNK, S2 | JUNK, 1'b1, 1'b0);
    req("R10", 2'd3, Q1, Q2, 1'b1, 1'b0);
    req("R10", 2'd3, Q2, Q1, 1'b0, 1'b0);
    // R11: quad disabled in second instance; NaNs there must not flag
    req("R11", 2'd3, QQN, Q1, 1'b1, 1'b0);
    req("R11", 2'd3, QSN, Q1, 1'b1, 1'b1);
    req("R11", 2'd3, Q1, Q1, 1'b0, 1'b0);
    req("R6", 2'd3, QQN, QQN, 1'b0, 1'b1);
    idle(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule